// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the memory side of taking and leaving an exception on a 32-bit core. It owns the core's instruction pointer, stack pointer, frame pointer and six-bit flag word. When a synchronous exception is raised, or a hardware interrupt arrives while interrupts are enabled, it reads a two-word vector entry that supplies a fresh IP and SP. On the fresh stack it stores the interrupted SP and flags, then a call frame of the interrupted IP and FP, then up to `2**ARGC_W-1` handler arguments. Finally it commits the new context with privilege raised and interrupts masked. A return request unwinds the same four words from the current SP and restores the interrupted context.

A fault reported by memory during entry or return restarts entry through a fixed double-fault vector with no arguments. It keeps the context that was interrupted in the first place. A fault during that double-fault entry stops the block for good: `halted` stays high and every request is ignored until reset. Arguments are fetched one at a time: the block drives `arg_sel` and reads the word on `arg_data` in the same cycle. Memory is a single-outstanding word port. A request is a one-cycle pulse, and the response (`mem_ack` with `mem_rdata` and `mem_err`) may come any later cycle. While idle, the core may overwrite the context through `ctx_we`.

Top module: `trap_seq`

## Requirements
- R1: After reset IP, SP and FP are 0, the flag word is 6'b000010 (bit 0 privileged, bit 1 interrupt enable, bits 2..5 equal, zero, overflow, sign), `busy`, `done` and `halted` are 0.
- R2: Entry with index k reads address VT_BASE+8k first, taking the new IP, then VT_BASE+8k+4, taking the new SP.
- R3: Each push lowers SP by 4 and then writes there. Starting from the vector SP, entry writes the old SP, the old flags (zero-extended), the old IP and the old FP, in that order.
- R4: After the frame, arg_cnt arguments are pushed in order, with `arg_sel` = 0,1,... Finally IP is the vector IP, FP is the vector SP minus 16, and SP is the vector SP minus 16 minus 4 per argument.
- R5: On completed entry the privileged bit is set, the interrupt-enable bit is cleared, and bits 2..5 keep their pre-entry values.
- R6: A hardware interrupt is ignored while the interrupt-enable bit is 0 (no memory access, no context change). A synchronous exception is taken regardless of that bit, and it wins over a simultaneous interrupt or return.
- R7: Return reads FP at SP, IP at SP+4, flags at SP+8 and SP at SP+12, and then loads all four into the context.
- R8: A memory error during entry or return restarts entry through vector DF_IDX with no arguments, saving the context that held before the failed sequence.
- R9: A memory error during the double-fault entry sets `halted`, leaves the context unchanged, and holds `halted` (ignoring all requests) until reset.
- R10: `mem_req` is a one-cycle pulse with no new request before the response. `busy` is high from the cycle after acceptance until completion, and `done` pulses for exactly one cycle together with the context update.
- R11: While idle with no request, `ctx_we` loads the four context values on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| irq_req | input | 1 | Hardware interrupt request |
| vec_idx | input | IDX_W | Vector table index for the request |
| arg_cnt | input | ARGC_W | Number of handler arguments |
| arg_sel | output | ARGC_W | Index of the argument being pushed |
| arg_data | input | 32 | Argument word selected by arg_sel |
| ret_req | input | 1 | Return-from-exception request |
| ctx_we | input | 1 | Context overwrite strobe |
| ctx_ip_in | input | 32 | IP to load |
| ctx_sp_in | input | 32 | SP to load |
| ctx_fp_in | input | 32 | FP to load |
| ctx_flags_in | input | 6 | Flag word to load |
| core_ip | output | 32 | Current IP |
| core_sp | output | 32 | Current SP |
| core_fp | output | 32 | Current FP |
| core_flags | output | 6 | Current flag word |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response valid |
| mem_err | input | 1 | Response carries a fault |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Core stopped after a nested fault |

## Verification
Nearly every internal slip in this block surfaces on the memory port first. A wrong step counter, stack pointer or saved word gives a wrong address, direction or data on the very next request. The scoreboard therefore compares every access in order, not just the final context. Errors in the commit path, such as wrong flag masking or a wrong FP or final SP, appear in the context outputs in the same cycle that `done` pulses. Fault escalation shows as the double-fault vector reads directly after the failing response, or as `halted` one cycle later with the memory port silent afterwards.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int XLEN        = 32;
  localparam int FLAG_W      = 6;
  localparam int FL_PRIV     = 0;
  localparam int FL_HWEN     = 1;
  localparam logic [FLAG_W-1:0] FLAGS_RST = 6'b000010;
  localparam int VEC_READS   = 2;
  localparam int FRAME_WORDS = 4;
  localparam int FIRST_ARG   = VEC_READS + FRAME_WORDS;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_HALT} seq_st_t;

  typedef struct packed {
    logic [XLEN-1:0]   ip;
    logic [XLEN-1:0]   sp;
    logic [XLEN-1:0]   fp;
    logic [FLAG_W-1:0] flags;
  } core_ctx_t;
endpackage

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs
  import trap_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ld_en,
  input  core_ctx_t ld_val,
  output core_ctx_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q.ip    <= '0;
      q.sp    <= '0;
      q.fp    <= '0;
      q.flags <= FLAGS_RST;
    end else if (ld_en) begin
      q <= ld_val;
    end
  end
endmodule

// File: rtl/trap_step_gen.sv
module trap_step_gen
  import trap_seq_pkg::*;
#(
  parameter int STEP_W = 6,
  parameter int ARGC_W = 3
) (
  input  logic              exit_mode,
  input  logic [STEP_W-1:0] step,
  input  logic [ARGC_W-1:0] argn,
  input  logic [XLEN-1:0]   vec_addr,
  input  logic [XLEN-1:0]   w_sp,
  input  core_ctx_t         saved,
  input  logic [XLEN-1:0]   arg_data,
  output logic [XLEN-1:0]   addr,
  output logic [XLEN-1:0]   wdata,
  output logic              we,
  output logic              last
);
  // Per-step address, direction and data for both sequences.
  always_comb begin
    addr  = w_sp - 32'd4;
    wdata = arg_data;
    we    = 1'b1;
    if (exit_mode) begin
      addr  = w_sp;
      wdata = '0;
      we    = 1'b0;
      last  = (step == STEP_W'(FRAME_WORDS - 1));
    end else begin
      last = (step == STEP_W'(FIRST_ARG - 1) + STEP_W'(argn));
      case (step)
        STEP_W'(0): begin addr = vec_addr;         we = 1'b0; end
        STEP_W'(1): begin addr = vec_addr + 32'd4; we = 1'b0; end
        STEP_W'(2): wdata = saved.sp;
        STEP_W'(3): wdata = XLEN'(saved.flags);
        STEP_W'(4): wdata = saved.ip;
        STEP_W'(5): wdata = saved.fp;
        default:    wdata = arg_data;
      endcase
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int          IDX_W   = 8,
  parameter int          ARGC_W  = 3,
  parameter logic [31:0] VT_BASE = 32'h0,
  parameter int          DF_IDX  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic              irq_req,
  input  logic [IDX_W-1:0]  vec_idx,
  input  logic [ARGC_W-1:0] arg_cnt,
  output logic [ARGC_W-1:0] arg_sel,
  input  logic [XLEN-1:0]   arg_data,
  input  logic              ret_req,
  input  logic              ctx_we,
  input  logic [XLEN-1:0]   ctx_ip_in,
  input  logic [XLEN-1:0]   ctx_sp_in,
  input  logic [XLEN-1:0]   ctx_fp_in,
  input  logic [FLAG_W-1:0] ctx_flags_in,
  output logic [XLEN-1:0]   core_ip,
  output logic [XLEN-1:0]   core_sp,
  output logic [XLEN-1:0]   core_fp,
  output logic [FLAG_W-1:0] core_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              halted
);
  localparam int STEP_W = ARGC_W + 3;

  seq_st_t             st;
  logic                exit_mode;
  logic                dbl;
  logic [IDX_W-1:0]    idx_q;
  logic [ARGC_W-1:0]   argn_q;
  logic [STEP_W-1:0]   step_q;
  logic [XLEN-1:0]     w_ip, w_sp, w_fp;
  logic [FLAG_W-1:0]   w_fl;
  core_ctx_t           saved, ctx, ld_val;
  logic                ctx_ld;
  logic [XLEN-1:0]     vec_addr, g_addr, g_wdata;
  logic                g_we, g_last;
  logic                idle, take_ent, take_ret, resp_ok, resp_bad, finish;
  logic [FLAG_W-1:0]   ent_flags;

  assign idle     = (st == ST_IDLE);
  assign take_ent = idle && (exc_req || (irq_req && ctx.flags[FL_HWEN]));
  assign take_ret = idle && !take_ent && ret_req;
  assign resp_ok  = (st == ST_WAIT) && mem_ack && !mem_err;
  assign resp_bad = (st == ST_WAIT) && mem_ack && mem_err;
  assign finish   = resp_ok && g_last;
  assign vec_addr = VT_BASE + (XLEN'(idx_q) << 3);
  assign arg_sel  = ARGC_W'(step_q - STEP_W'(FIRST_ARG));
  assign busy     = (st == ST_ISSUE) || (st == ST_WAIT);

  always_comb begin
    ent_flags          = saved.flags;
    ent_flags[FL_PRIV] = 1'b1;
    ent_flags[FL_HWEN] = 1'b0;
  end

  trap_step_gen #(.STEP_W(STEP_W), .ARGC_W(ARGC_W)) u_step (
    .exit_mode (exit_mode),
    .step      (step_q),
    .argn      (argn_q),
    .vec_addr  (vec_addr),
    .w_sp      (w_sp),
    .saved     (saved),
    .arg_data  (arg_data),
    .addr      (g_addr),
    .wdata     (g_wdata),
    .we        (g_we),
    .last      (g_last)
  );

  // Context load: sequence commit, or a core overwrite while idle.
  always_comb begin
    ctx_ld = finish || (idle && ctx_we && !take_ent && !ret_req);
    ld_val = '{ip: ctx_ip_in, sp: ctx_sp_in, fp: ctx_fp_in, flags: ctx_flags_in};
    if (finish) begin
      if (exit_mode) begin
        ld_val = '{ip: w_ip, sp: mem_rdata, fp: w_fp, flags: w_fl};
      end else begin
        ld_val = '{ip: w_ip, sp: w_sp - 32'd4,
                   fp: (step_q == STEP_W'(FIRST_ARG - 1)) ? w_sp - 32'd4 : w_fp,
                   flags: ent_flags};
      end
    end
  end

  trap_ctx_regs u_ctx (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ctx_ld),
    .ld_val (ld_val),
    .q      (ctx)
  );

  assign core_ip    = ctx.ip;
  assign core_sp    = ctx.sp;
  assign core_fp    = ctx.fp;
  assign core_flags = ctx.flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      exit_mode <= 1'b0;
      dbl       <= 1'b0;
      idx_q     <= '0;
      argn_q    <= '0;
      step_q    <= '0;
      w_ip      <= '0;
      w_sp      <= '0;
      w_fp      <= '0;
      w_fl      <= '0;
      saved     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      halted    <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take_ent || take_ret) begin
            st        <= ST_ISSUE;
            exit_mode <= take_ret;
            dbl       <= 1'b0;
            idx_q     <= vec_idx;
            argn_q    <= take_ent ? arg_cnt : '0;
            step_q    <= '0;
            saved     <= ctx;
            w_sp      <= ctx.sp;
          end
        end
        ST_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= g_we;
          mem_addr  <= g_addr;
          mem_wdata <= g_wdata;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_bad) begin
            if (dbl) begin
              st     <= ST_HALT;
              halted <= 1'b1;
            end else begin
              st        <= ST_ISSUE;
              dbl       <= 1'b1;
              exit_mode <= 1'b0;
              idx_q     <= IDX_W'(DF_IDX);
              argn_q    <= '0;
              step_q    <= '0;
            end
          end else if (resp_ok) begin
            if (exit_mode) begin
              w_sp <= w_sp + 32'd4;
              case (step_q)
                STEP_W'(0): w_fp <= mem_rdata;
                STEP_W'(1): w_ip <= mem_rdata;
                STEP_W'(2): w_fl <= mem_rdata[FLAG_W-1:0];
                default: ;
              endcase
            end else begin
              case (step_q)
                STEP_W'(0): w_ip <= mem_rdata;
                STEP_W'(1): w_sp <= mem_rdata;
                STEP_W'(5): begin w_sp <= w_sp - 32'd4; w_fp <= w_sp - 32'd4; end
                default:    w_sp <= w_sp - 32'd4;
              endcase
            end
            if (g_last) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st     <= ST_ISSUE;
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              halted,
  input logic              mem_req,
  input logic              exc_req,
  input logic              irq_req,
  input logic              ret_req,
  input logic              exit_mode,
  input logic [FLAG_W-1:0] core_flags
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (core_flags == FLAGS_RST && !halted && !busy && !done));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!busy && !mem_req));

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R5
  entry_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !exit_mode) |-> (core_flags[FL_PRIV] && !core_flags[FL_HWEN]));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !halted && !core_flags[FL_HWEN] && irq_req && !exc_req && !ret_req)
      |=> !busy);
endmodule

bind trap_seq trap_seq_chk u_trap_seq_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .halted     (halted),
  .mem_req    (mem_req),
  .exc_req    (exc_req),
  .irq_req    (irq_req),
  .ret_req    (ret_req),
  .exit_mode  (exit_mode),
  .core_flags (core_flags)
);

// File: tb/trap_seq_tb_top.sv
module trap_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        exc_req = 0, irq_req = 0, ret_req = 0, ctx_we = 0;
  logic [7:0]  vec_idx = '0;
  logic [2:0]  arg_cnt = '0, arg_sel;
  logic [31:0] arg_data;
  logic [31:0] ctx_ip_in = '0, ctx_sp_in = '0, ctx_fp_in = '0;
  logic [5:0]  ctx_flags_in = '0;
  logic [31:0] core_ip, core_sp, core_fp;
  logic [5:0]  core_flags;
  logic        mem_req, mem_we, busy, done, halted;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = '0;

  assign arg_data = 32'hA000_0000 | 32'(arg_sel);

  trap_seq dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .irq_req(irq_req), .vec_idx(vec_idx),
    .arg_cnt(arg_cnt), .arg_sel(arg_sel), .arg_data(arg_data), .ret_req(ret_req),
    .ctx_we(ctx_we), .ctx_ip_in(ctx_ip_in), .ctx_sp_in(ctx_sp_in), .ctx_fp_in(ctx_fp_in),
    .ctx_flags_in(ctx_flags_in), .core_ip(core_ip), .core_sp(core_sp), .core_fp(core_fp),
    .core_flags(core_flags), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .halted(halted)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard of expected memory accesses.
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } acc_t;
  acc_t exp_q[$];

  task automatic exp_rd(input logic [31:0] a, input string tag);
    acc_t e; e.we = 0; e.addr = a; e.data = '0; e.tag = tag; exp_q.push_back(e);
  endtask
  task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    acc_t e; e.we = 1; e.addr = a; e.data = d; e.tag = tag; exp_q.push_back(e);
  endtask

  logic [31:0] mem [int];
  logic [31:0] err_a = 32'h1, err_b = 32'h1;

  // Memory model and monitor, away from the active edge.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (mem_req) begin
      mem_ack = 1'b1;
      mem_err = (mem_addr == err_a) || (mem_addr == err_b);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/extra access", mem_addr, 32'h0);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr, e.tag, {mem_we, mem_addr[30:0]}, {e.we, e.addr[30:0]});
        if (e.we) chk(mem_wdata == e.data, e.tag, mem_wdata, e.data);
      end
      if (mem_we && !mem_err) mem[int'(mem_addr)] = mem_wdata;
      mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 32'h0;
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk_ctx(input logic [31:0] ip, sp, fp, input logic [5:0] fl, input string tag);
    chk(core_ip == ip, tag, core_ip, ip);
    chk(core_sp == sp, tag, core_sp, sp);
    chk(core_fp == fp, tag, core_fp, fp);
    chk(core_flags == fl, tag, 32'(core_flags), 32'(fl));
  endtask

  task automatic load_ctx(input logic [31:0] ip, sp, fp, input logic [5:0] fl);
    @(negedge clk);
    ctx_we = 1; ctx_ip_in = ip; ctx_sp_in = sp; ctx_fp_in = fp; ctx_flags_in = fl;
    @(negedge clk);
    ctx_we = 0;
  endtask

  task automatic raise(input bit is_irq, input bit is_ret, input logic [7:0] idx, input logic [2:0] n);
    @(negedge clk);
    vec_idx = idx; arg_cnt = n;
    if (is_ret) ret_req = 1; else if (is_irq) irq_req = 1; else exc_req = 1;
    @(negedge clk);
    exc_req = 0; irq_req = 0; ret_req = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'h1);
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, 32'(done), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    report();
  end

  initial begin
    mem[0 + 24] = 32'h0000_0400; mem[28] = 32'h0000_9000;
    mem[40]     = 32'h0000_0500; mem[44] = 32'h0000_A000;
    mem[48]     = 32'h0000_0600; mem[52] = 32'h0000_B000;
    mem[64]     = 32'h0000_0800; mem[68] = 32'h0000_C000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_ctx(32'h0, 32'h0, 32'h0, 6'b000010, "R1");
    chk(!busy && !done && !halted, "R1 status", {busy, done, halted}, 32'h0);

    // R11 context overwrite
    load_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e);
    chk_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e, "R11");

    // R2 R3 R4 R5: exception index 3, two arguments
    exp_rd(32'd24, "R2"); exp_rd(32'd28, "R2");
    exp_wr(32'h8ffc, 32'h8000, "R3"); exp_wr(32'h8ff8, 32'h0e, "R3");
    exp_wr(32'h8ff4, 32'h100, "R3"); exp_wr(32'h8ff0, 32'h7ff0, "R3");
    exp_wr(32'h8fec, 32'hA000_0000, "R4"); exp_wr(32'h8fe8, 32'hA000_0001, "R4");
    raise(0, 0, 8'd3, 3'd2);
    wait_done("R10 done");
    chk_ctx(32'h400, 32'h8fe8, 32'h8ff0, 6'h0d, "R4/R5 entry context");
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'h0);
    chk(exp_q.size() == 0, "R3 all accesses", exp_q.size(), 0);

    // R6: masked interrupt ignored
    @(negedge clk); irq_req = 1; vec_idx = 8'd5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R6 masked irq", 32'(busy), 32'h0);
    end
    irq_req = 0;
    chk_ctx(32'h400, 32'h8fe8, 32'h8ff0, 6'h0d, "R6 context kept");

    // R7: handler drops its arguments, then returns
    load_ctx(32'h400, 32'h8ff0, 32'h8ff0, 6'h0d);
    exp_rd(32'h8ff0, "R7"); exp_rd(32'h8ff4, "R7"); exp_rd(32'h8ff8, "R7"); exp_rd(32'h8ffc, "R7");
    raise(0, 1, 8'd0, 3'd0);
    wait_done("R7 done");
    chk_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e, "R7 restored");
    chk(exp_q.size() == 0, "R7 all accesses", exp_q.size(), 0);

    // R6: enabled interrupt, no arguments
    exp_rd(32'd40, "R6"); exp_rd(32'd44, "R6");
    exp_wr(32'h9ffc, 32'h8000, "R6"); exp_wr(32'h9ff8, 32'h0e, "R6");
    exp_wr(32'h9ff4, 32'h100, "R6"); exp_wr(32'h9ff0, 32'h7ff0, "R6");
    raise(1, 0, 8'd5, 3'd0);
    wait_done("R6 irq done");
    chk_ctx(32'h500, 32'h9ff0, 32'h9ff0, 6'h0d, "R4 zero args");

    // R6: exception taken with interrupts masked, winning over a return
    exp_rd(32'd24, "R6"); exp_rd(32'd28, "R6");
    exp_wr(32'h8ffc, 32'h9ff0, "R6"); exp_wr(32'h8ff8, 32'h0d, "R6");
    exp_wr(32'h8ff4, 32'h500, "R6"); exp_wr(32'h8ff0, 32'h9ff0, "R6");
    @(negedge clk); exc_req = 1; ret_req = 1; vec_idx = 8'd3; arg_cnt = 3'd0;
    @(negedge clk); exc_req = 0; ret_req = 0;
    wait_done("R6 exc priority");
    chk_ctx(32'h400, 32'h8ff0, 32'h8ff0, 6'h0d, "R6 exc context");

    // R8: fault on the flags push escalates to the double-fault vector
    load_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e);
    err_a = 32'haff8;
    exp_rd(32'd48, "R8"); exp_rd(32'd52, "R8");
    exp_wr(32'haffc, 32'h8000, "R8"); exp_wr(32'haff8, 32'h0e, "R8");
    exp_rd(32'd64, "R8"); exp_rd(32'd68, "R8");
    exp_wr(32'hbffc, 32'h8000, "R8"); exp_wr(32'hbff8, 32'h0e, "R8");
    exp_wr(32'hbff4, 32'h100, "R8"); exp_wr(32'hbff0, 32'h7ff0, "R8");
    raise(0, 0, 8'd6, 3'd1);
    wait_done("R8 done");
    chk_ctx(32'h800, 32'hbff0, 32'hbff0, 6'h0d, "R8 context");
    chk(halted == 1'b0, "R8 not halted", 32'(halted), 32'h0);

    // R9: second fault inside double-fault entry halts
    load_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e);
    err_b = 32'hbff4;
    exp_rd(32'd48, "R9"); exp_rd(32'd52, "R9");
    exp_wr(32'haffc, 32'h8000, "R9"); exp_wr(32'haff8, 32'h0e, "R9");
    exp_rd(32'd64, "R9"); exp_rd(32'd68, "R9");
    exp_wr(32'hbffc, 32'h8000, "R9"); exp_wr(32'hbff8, 32'h0e, "R9");
    exp_wr(32'hbff4, 32'h100, "R9");
    raise(0, 0, 8'd6, 3'd0);
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    chk(halted == 1'b1, "R9 halted", 32'(halted), 32'h1);
    chk_ctx(32'h100, 32'h8000, 32'h7ff0, 6'h0e, "R9 context kept");
    raise(0, 0, 8'd3, 3'd0);
    repeat (6) @(negedge clk);
    chk(halted == 1'b1 && busy == 1'b0, "R9 sticky", {halted, busy}, 32'h2);
    chk(exp_q.size() == 0, "R9 all accesses", exp_q.size(), 0);

    // R1/R9: reset clears the halt
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk(halted == 1'b0, "R9 reset clears halt", 32'(halted), 32'h0);
    chk_ctx(32'h0, 32'h0, 32'h0, 6'b000010, "R1 after second reset");
    report();
  end
endmodule